// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a general-purpose timer. It watches a shared free-running counter and works in one of three ways: as an input capture that records the counter value on a chosen pin edge, as an output compare that acts on its pin when the counter reaches a compare value, or as a buffered compare for PWM, where new compare values take effect only at counter overflow. A two-bit mode field and a two-bit edge/level field select the behaviour. When the edge/level field is zero the channel gives the pin back to general-purpose I/O and holds a preset output level, chosen by the low mode bit.

The channel keeps its configuration in a small state machine with four states: `CH_OFF` (pin released, preset level held), `CH_CAPT` (input capture), `CH_OCMP` (plain output compare) and `CH_BUFC` (buffered compare/PWM). Every accepted control write is a transition. The state is decoded from the new mode and edge/level values: `CH_OFF` whenever edge/level is 00, otherwise `CH_CAPT` for mode 00, `CH_OCMP` for mode 01 and `CH_BUFC` for mode 1X. This covers every pair of states, including a state moving to itself. Mode bits are accepted only while the counter is stopped and held in reset. Edge/level bits are accepted on any control write.

Top module: `tmr_chan`

## Requirements
- R1: After reset the mode and edge/level fields read 00, pin_en is 0, pin_out is 1, cap_value is 0 and chan_flag is 0.
- R2: While edge/level is 00, pin_en is 0 and pin_out follows the preset level one clock later: mode bit 0 set gives 0, mode bit 0 clear gives 1.
- R3: While edge/level is 00, no capture or compare event occurs: chan_flag never sets and cap_value does not change.
- R4: A control write updates the mode field only when cnt_stopped and cnt_held are both 1. Otherwise the mode field is unchanged. The edge/level field is updated on every control write.
- R5: In mode 00, edge/level 01 captures on rising edges, 10 on falling edges and 11 on both. The pin passes through two synchronizer flops. A level first sampled at clock edge k is compared with the level sampled at edge k-1, and a capture at edge k+2 loads the counter value present before that edge into cap_value and sets chan_flag.
- R6: In mode 01 or 1X, when cnt_value equals the active compare value, the next clock edge applies the action chosen by edge/level to pin_out (01 toggle, 10 clear, 11 set) and sets chan_flag.
- R7: In mode 1X, a compare write goes only to a shadow register. The active compare value takes the shadow value at the clock edge where cnt_ovf is 1. If the write and the overflow fall in the same cycle, the active value takes the older shadow value.
- R8: In modes other than 1X, a compare write loads both the active and the shadow compare values at the next clock edge.
- R9: flag_ack clears chan_flag at the next edge. A capture or compare event in the same cycle wins and leaves the flag set.
- R10: pin_en is 1 whenever edge/level is not 00. In capture mode pin_out keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_value | input | CNT_W | Shared counter value |
| cnt_stopped | input | 1 | Counter is stopped |
| cnt_held | input | 1 | Counter is held in reset |
| cnt_ovf | input | 1 | Counter wraps at this edge |
| pin_in | input | 1 | External pin level (asynchronous) |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | CNT_W | Compare value to write |
| ctl_wr | input | 1 | Control write strobe |
| ctl_mode | input | 2 | Mode field to write |
| ctl_sel | input | 2 | Edge/level field to write |
| flag_ack | input | 1 | Clears the channel flag |
| cfg_mode | output | 2 | Current mode field |
| cfg_sel | output | 2 | Current edge/level field |
| pin_out | output | 1 | Timer drive level for the pin |
| pin_en | output | 1 | 1 when the timer owns the pin |
| cap_value | output | CNT_W | Last captured counter value |
| chan_flag | output | 1 | Channel event flag |

## Verification
The two functions that can fall in the same cycle are setting the flag on an event and clearing it with an acknowledge. A second pair is a buffered compare write arriving with a counter overflow. The bench holds flag_ack high through whole compare periods, so acknowledges land on match cycles. It then checks that the flag still reads 1 after those cycles. Buffered writes are issued while the counter runs across its wrap. A behavioural model of the pin history, the compare registers and the flag is compared against the outputs on every clock, and it decides which of the two colliding actions each register must show.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    typedef enum logic [1:0] {
        CH_OFF  = 2'b00,
        CH_CAPT = 2'b01,
        CH_OCMP = 2'b10,
        CH_BUFC = 2'b11
    } chan_st_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } pin_act_e;

    function automatic chan_st_e decode_state(input logic [1:0] mode, input logic [1:0] sel);
        chan_st_e st;
        if (sel == 2'b00)       st = CH_OFF;
        else if (mode[1])       st = CH_BUFC;
        else if (mode[0])       st = CH_OCMP;
        else                    st = CH_CAPT;
        return st;
    endfunction

endpackage

// File: rtl/tmr_chan_ctrl.sv
module tmr_chan_ctrl
    import tmr_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [1:0] ctl_mode,
    input  logic [1:0] ctl_sel,
    input  logic       cnt_stopped,
    input  logic       cnt_held,
    output logic [1:0] mode_q,
    output logic [1:0] sel_q,
    output chan_st_e   state_q,
    output logic       capt_en,
    output logic       rise_en,
    output logic       fall_en,
    output logic       cmp_en,
    output logic       buf_en,
    output logic       pin_own,
    output logic       preset_lvl,
    output pin_act_e   action
);

    logic       mode_we;
    logic [1:0] mode_d;
    logic [1:0] sel_d;
    chan_st_e   state_d;

    // Mode bits are accepted only while the counter is frozen at zero.
    assign mode_we = ctl_wr && cnt_stopped && cnt_held;
    assign mode_d  = mode_we ? ctl_mode : mode_q;
    assign sel_d   = ctl_wr  ? ctl_sel  : sel_q;
    assign state_d = decode_state(mode_d, sel_d);

    // State register together with the configuration it is decoded from.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= 2'b00;
            sel_q   <= 2'b00;
            state_q <= CH_OFF;
        end else begin
            mode_q  <= mode_d;
            sel_q   <= sel_d;
            state_q <= state_d;
        end
    end

    // Per-state enables.
    always_comb begin
        capt_en    = 1'b0;
        rise_en    = 1'b0;
        fall_en    = 1'b0;
        cmp_en     = 1'b0;
        buf_en     = 1'b0;
        pin_own    = 1'b1;
        preset_lvl = ~mode_q[0];
        action     = ACT_NONE;
        unique case (state_q)
            CH_OFF: begin
                pin_own = 1'b0;
            end
            CH_CAPT: begin
                capt_en = 1'b1;
                rise_en = sel_q[0];
                fall_en = sel_q[1];
            end
            CH_OCMP: begin
                cmp_en = 1'b1;
                action = pin_act_e'(sel_q);
            end
            CH_BUFC: begin
                cmp_en = 1'b1;
                buf_en = 1'b1;
                action = pin_act_e'(sel_q);
            end
            default: begin
                pin_own = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tmr_chan_capture.sv
module tmr_chan_capture #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic             capt_en,
    input  logic             rise_en,
    input  logic             fall_en,
    input  logic [CNT_W-1:0] cnt_value,
    output logic [CNT_W-1:0] cap_q,
    output logic             capt_evt
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;
    logic          rise_det;
    logic          fall_det;

    // Synchronizer chain, its depth set by the parameter.
    genvar g;
    generate
        for (g = 0; g <= LAST; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= pin_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    assign rise_det = sync_q[LAST] & ~prev_q;
    assign fall_det = ~sync_q[LAST] & prev_q;
    assign capt_evt = capt_en && ((rise_en && rise_det) || (fall_en && fall_det));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cap_q <= '0;
        else if (capt_evt) cap_q <= cnt_value;
    end

endmodule

// File: rtl/tmr_chan_compare.sv
module tmr_chan_compare #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             buf_en,
    input  logic             cmp_en,
    input  logic             cnt_ovf,
    input  logic [CNT_W-1:0] cnt_value,
    output logic             cmp_evt
);

    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
        end else if (buf_en) begin
            // Buffered: writes stage in the shadow, overflow publishes it.
            if (cmp_wr)  shadow_q <= cmp_wdata;
            if (cnt_ovf) active_q <= shadow_q;
        end else if (cmp_wr) begin
            shadow_q <= cmp_wdata;
            active_q <= cmp_wdata;
        end
    end

    assign cmp_evt = cmp_en && (cnt_value == active_q);

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_value,
    input  logic             cnt_stopped,
    input  logic             cnt_held,
    input  logic             cnt_ovf,
    input  logic             pin_in,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             ctl_wr,
    input  logic [1:0]       ctl_mode,
    input  logic [1:0]       ctl_sel,
    input  logic             flag_ack,
    output logic [1:0]       cfg_mode,
    output logic [1:0]       cfg_sel,
    output logic             pin_out,
    output logic             pin_en,
    output logic [CNT_W-1:0] cap_value,
    output logic             chan_flag
);

    chan_st_e state_q;
    pin_act_e action;
    logic     capt_en, rise_en, fall_en, cmp_en, buf_en, pin_own, preset_lvl;
    logic     capt_evt, cmp_evt;
    logic     out_q, flag_q;

    tmr_chan_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_mode   (ctl_mode),
        .ctl_sel    (ctl_sel),
        .cnt_stopped(cnt_stopped),
        .cnt_held   (cnt_held),
        .mode_q     (cfg_mode),
        .sel_q      (cfg_sel),
        .state_q    (state_q),
        .capt_en    (capt_en),
        .rise_en    (rise_en),
        .fall_en    (fall_en),
        .cmp_en     (cmp_en),
        .buf_en     (buf_en),
        .pin_own    (pin_own),
        .preset_lvl (preset_lvl),
        .action     (action)
    );

    tmr_chan_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) capt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .capt_en  (capt_en),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .cnt_value(cnt_value),
        .cap_q    (cap_value),
        .capt_evt (capt_evt)
    );

    tmr_chan_compare #(.CNT_W(CNT_W)) cmp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_wr   (cmp_wr),
        .cmp_wdata(cmp_wdata),
        .buf_en   (buf_en),
        .cmp_en   (cmp_en),
        .cnt_ovf  (cnt_ovf),
        .cnt_value(cnt_value),
        .cmp_evt  (cmp_evt)
    );

    // Output register: preset while released, compare action otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b1;
        end else if (state_q == CH_OFF) begin
            out_q <= preset_lvl;
        end else if (cmp_evt) begin
            unique case (action)
                ACT_TOGGLE: out_q <= ~out_q;
                ACT_CLEAR:  out_q <= 1'b0;
                ACT_SET:    out_q <= 1'b1;
                default:    out_q <= out_q;
            endcase
        end
    end

    // Event flag: a new event outranks the acknowledge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  flag_q <= 1'b0;
        else if (capt_evt | cmp_evt) flag_q <= 1'b1;
        else if (flag_ack)           flag_q <= 1'b0;
    end

    assign pin_out   = out_q;
    assign pin_en    = pin_own;
    assign chan_flag = flag_q;

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_stopped,
    input logic             cnt_held,
    input logic             ctl_wr,
    input logic             flag_ack,
    input logic [1:0]       cfg_mode,
    input logic [1:0]       cfg_sel,
    input logic             pin_out,
    input logic             pin_en,
    input logic [CNT_W-1:0] cap_value,
    input logic             chan_flag
);

    // R2: released channel settles on the preset level.
    assert_idle_preset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == 2'b00 && !ctl_wr) |=> (pin_out == ~cfg_mode[0]));

    // R3: released channel with acknowledge leaves the flag low.
    assert_idle_no_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == 2'b00 && !ctl_wr && flag_ack) |=> !chan_flag);

    // R4: mode write outside the frozen-counter window is dropped.
    assert_mode_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !(cnt_stopped && cnt_held)) |=> $stable(cfg_mode));

    // R5: the capture register only moves together with the flag.
    assert_capture_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_value) |-> chan_flag);

    // R9: the flag is sticky until acknowledged.
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_flag && !flag_ack) |=> chan_flag);

    // R10: capture mode never moves the pin level.
    assert_capture_pin_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b00 && cfg_sel != 2'b00 && !ctl_wr) |=> $stable(pin_out));

    // R10: ownership tracks the edge/level field.
    assert_pin_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pin_en == (cfg_sel != 2'b00));

endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_stopped(cnt_stopped),
    .cnt_held   (cnt_held),
    .ctl_wr     (ctl_wr),
    .flag_ack   (flag_ack),
    .cfg_mode   (cfg_mode),
    .cfg_sel    (cfg_sel),
    .pin_out    (pin_out),
    .pin_en     (pin_en),
    .cap_value  (cap_value),
    .chan_flag  (chan_flag)
);

// File: tb/tmr_chan_tb_top.sv
module tmr_chan_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt = '0;
    logic         run = 1'b0;
    logic         cnt_ovf;
    logic         pin_in = 1'b0;
    logic         cmp_wr = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic         ctl_wr = 1'b0;
    logic [1:0]   ctl_mode = 2'b00;
    logic [1:0]   ctl_sel = 2'b00;
    logic         flag_ack = 1'b0;
    logic [1:0]   cfg_mode, cfg_sel;
    logic         pin_out, pin_en, chan_flag;
    logic [W-1:0] cap_value;

    int errors = 0;
    int checks = 0;
    int coll_hits = 0;

    always #10 clk = ~clk;

    assign cnt_ovf = run && (cnt == {W{1'b1}});

    always @(negedge clk) begin
        if (!run) cnt <= '0;
        else      cnt <= cnt + 1'b1;
    end

    tmr_chan #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_value(cnt), .cnt_stopped(!run),
        .cnt_held(!run), .cnt_ovf(cnt_ovf), .pin_in(pin_in), .cmp_wr(cmp_wr),
        .cmp_wdata(cmp_wdata), .ctl_wr(ctl_wr), .ctl_mode(ctl_mode),
        .ctl_sel(ctl_sel), .flag_ack(flag_ack), .cfg_mode(cfg_mode),
        .cfg_sel(cfg_sel), .pin_out(pin_out), .pin_en(pin_en),
        .cap_value(cap_value), .chan_flag(chan_flag)
    );

    // Behavioural reference model.
    logic [1:0]   m_mode, m_sel;
    logic         m_out, m_flag;
    logic [W-1:0] m_cap, m_act, m_shd;
    logic         hist[$];
    logic         m_rise, m_fall, m_capt, m_hit;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_sel = 0; m_out = 1; m_flag = 0;
            m_cap = 0; m_act = 0; m_shd = 0;
            hist = '{1'b0, 1'b0, 1'b0};
        end else begin
            m_rise = hist[1] && !hist[2];
            m_fall = !hist[1] && hist[2];
            m_capt = (m_mode == 0) && (m_sel != 0) &&
                     ((m_sel[0] && m_rise) || (m_sel[1] && m_fall));
            m_hit  = (m_mode != 0) && (m_sel != 0) && (cnt == m_act);
            if (m_capt) m_cap = cnt;
            if (m_sel == 0) m_out = !m_mode[0];
            else if (m_hit) begin
                if (m_sel == 2'b01)      m_out = !m_out;
                else if (m_sel == 2'b10) m_out = 1'b0;
                else                     m_out = 1'b1;
            end
            if (m_capt || m_hit) m_flag = 1;
            else if (flag_ack)   m_flag = 0;
            if (m_mode[1]) begin
                if (cnt_ovf) m_act = m_shd;
                if (cmp_wr)  m_shd = cmp_wdata;
            end else if (cmp_wr) begin
                m_act = cmp_wdata; m_shd = cmp_wdata;
            end
            if (ctl_wr) begin
                if (!run) m_mode = ctl_mode;
                m_sel = ctl_sel;
            end
            hist.push_front(pin_in);
            void'(hist.pop_back());
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4", "cfg_mode", cfg_mode, m_mode);
            chk("R4", "cfg_sel", cfg_sel, m_sel);
            chk("R5", "cap_value", cap_value, m_cap);
            chk("R6", "pin_out", pin_out, m_out);
            chk("R9", "chan_flag", chan_flag, m_flag);
            chk("R10", "pin_en", pin_en, m_sel != 0);
            if (flag_ack && chan_flag) coll_hits++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic [1:0] s);
        @(negedge clk);
        ctl_mode = m; ctl_sel = s; ctl_wr = 1;
        @(negedge clk);
        ctl_wr = 0;
    endtask

    task automatic wr_cmp(input logic [W-1:0] v);
        @(negedge clk);
        cmp_wdata = v; cmp_wr = 1;
        @(negedge clk);
        cmp_wr = 0;
    endtask

    task automatic ack;
        @(negedge clk);
        flag_ack = 1;
        @(negedge clk);
        flag_ack = 0;
    endtask

    task automatic wait_cnt(input logic [W-1:0] v);
        do @(negedge clk); while (cnt != v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1: reset state
        chk("R1", "pin_out", pin_out, 1);
        chk("R1", "pin_en", pin_en, 0);
        chk("R1", "chan_flag", chan_flag, 0);
        chk("R1", "cap_value", cap_value, 0);
        chk("R1", "cfg_mode", cfg_mode, 0);

        // R2: preset levels while released
        set_cfg(2'b01, 2'b00);
        cyc(2);
        chk("R2", "preset low", pin_out, 0);
        chk("R2", "pin_en", pin_en, 0);
        set_cfg(2'b00, 2'b00);
        cyc(2);
        chk("R2", "preset high", pin_out, 1);

        // R3: no events while released, even with pin activity and matches
        set_cfg(2'b01, 2'b00);
        wr_cmp(8'h10);
        run = 1;
        for (int i = 0; i < 6; i++) begin
            cyc(7); pin_in = ~pin_in;
        end
        cyc(300);
        chk("R3", "flag idle", chan_flag, 0);
        chk("R3", "cap idle", cap_value, 0);

        // R4: mode write while counter runs is dropped, edge/level taken
        set_cfg(2'b10, 2'b01);
        cyc(1);
        chk("R4", "mode locked", cfg_mode, 2'b01);
        chk("R4", "sel taken", cfg_sel, 2'b01);
        cyc(300);
        run = 0;
        cyc(2);

        // R5: capture edges
        pin_in = 0;
        set_cfg(2'b00, 2'b01);
        ack();
        run = 1;
        for (int i = 0; i < 6; i++) begin
            cyc(9 + i); pin_in = ~pin_in;
            if (i == 2) ack();
        end
        cyc(8);
        ack();
        pin_in = 1;
        cyc(6);
        ack();
        pin_in = 0;
        cyc(6);
        chk("R5", "no capture on fall in rising mode", chan_flag, 0);
        set_cfg(2'b00, 2'b10);
        for (int i = 0; i < 6; i++) begin
            cyc(11); pin_in = ~pin_in; ack();
        end
        set_cfg(2'b00, 2'b11);
        for (int i = 0; i < 8; i++) begin
            cyc(5 + i); pin_in = ~pin_in;
            if (i[0]) ack();
        end
        cyc(8);
        chk("R5", "capture both edges flag", chan_flag, 1);
        run = 0;
        cyc(2);

        // R8, R6: plain compare
        set_cfg(2'b01, 2'b01);
        wr_cmp(8'h05);
        ack();
        run = 1;
        cyc(12);
        chk("R8", "direct compare load", chan_flag, 1);
        wr_cmp(8'h20);
        cyc(520);
        set_cfg(2'b01, 2'b10);
        cyc(300);
        set_cfg(2'b01, 2'b11);
        cyc(300);
        set_cfg(2'b01, 2'b01);
        cyc(260);

        // R9: acknowledge held through matches
        flag_ack = 1;
        coll_hits = 0;
        cyc(600);
        flag_ack = 0;
        chk("R9", "event beats ack", coll_hits > 0, 1);

        // R7: buffered compare
        run = 0;
        cyc(2);
        wr_cmp(8'h20);
        set_cfg(2'b10, 2'b01);
        wr_cmp(8'h40);
        run = 1;
        wait_cnt(8'h30);
        ack();
        wait_cnt(8'h50);
        chk("R7", "shadow not yet active", chan_flag, 0);
        wait_cnt(8'h50);
        chk("R7", "shadow active after wrap", chan_flag, 1);
        // write colliding with overflow
        wait_cnt(8'hFE);
        wr_cmp(8'h80);
        cyc(600);
        set_cfg(2'b10, 2'b10);
        cyc(280);
        run = 0;
        cyc(2);
        set_cfg(2'b11, 2'b11);
        run = 1;
        cyc(300);
        run = 0;
        cyc(4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule